// File: doc/BRIEF.md
# Synchronous Slave-FIFO Write Sequencer

This block sits on the external-master side of a synchronous slave FIFO port and turns transfer requests into the port's write sequence. A request names a target buffer address, a byte count and a flag asking for a short-packet commit at the end. The sequencer drives the buffer address and chip select, holds a one-cycle address-setup lead, and then streams the bytes with one write strobe per clock. It pauses whenever the peripheral reports its buffer full. It places the packet-end strobe according to how many bytes are pending since the last commit. All port signals are active high and synchronous to `clk`.

Bytes come from a local source. `src_data` is passed to the FIFO data bus, and `src_pop` tells the source that the byte was written on that edge. The block keeps a running count of bytes modulo the automatic commit length `AUTO_LEN` across requests. This count is cleared by every packet-end.

The controller has five states:

- ST_IDLE: ready, nothing driven.
- ST_SETUP: chip select and address driven, no strobe.
- ST_WRITE: burst.
- ST_PEND: packet-end alone.
- ST_DONE: completion pulse.

The transitions are:

- IDLE→SETUP when a request is accepted.
- SETUP→WRITE for a non-zero count.
- SETUP→PEND for a zero count with the commit flag set.
- SETUP→DONE for a zero count without the commit flag.
- WRITE→PEND when the final byte needs a deferred commit.
- WRITE→DONE after the final byte in every other case.
- PEND→DONE after the packet-end cycle.
- DONE→IDLE after the completion pulse.

Top module: `sfifo_wr_master`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken on an edge where `req_valid` and `req_ready` are both high, and request inputs are ignored in every other cycle.
- R2: The cycle after acceptance is an address-setup cycle. In that cycle `if_cs` is high, `if_addr` equals the accepted address, and `if_wr` and `if_pkt_end` are low, so the first strobe comes at least one full cycle after the address.
- R3: `if_cs` is high in every cycle in which `if_wr` or `if_pkt_end` is high.
- R4: During the burst, `if_wr` is high in every cycle with `fifo_full` low until exactly `req_len` bytes are written. In each such cycle `if_data` equals `src_data` and `src_pop` is high.
- R5: `if_wr` is low in every cycle in which `fifo_full` is high. The burst resumes on the first cycle with `fifo_full` low.
- R6: `if_addr` stays constant in every cycle of a request in which `if_cs` is high, including packet-end cycles.
- R7: With the commit flag set and a pending count before the final byte between 1 and AUTO_LEN-2, `if_pkt_end` is raised together with the final write strobe.
- R8: With the commit flag set and a pending count of 0 before the final byte, the final byte is written without packet-end. Packet-end then follows alone (`if_wr` low, `if_cs` high) on the next cycle.
- R9: With a pending count of AUTO_LEN-1 before the final byte, that byte completes an automatic packet and no packet-end is issued for the request.
- R10: A zero-count request with the commit flag set issues one lone packet-end cycle right after the setup cycle. Without the flag, it goes from setup straight to completion.
- R11: `req_done` is high for exactly one cycle, the cycle after the final byte or packet-end. In that cycle `if_cs`, `if_wr` and `if_pkt_end` are low, and `req_ready` is high on the cycle after it.
- R12: While `rst_n` is low, and on release, the block is idle: `req_ready` is high and `if_cs`, `if_wr`, `if_pkt_end` and `req_done` are low. The pending count is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Target buffer address |
| req_len | input | LEN_W | Number of bytes to write |
| req_pkt_end | input | 1 | Ask for a short-packet commit at the end |
| req_done | output | 1 | One-cycle completion pulse |
| src_data | input | DATA_W | Next byte from the local source |
| src_pop | output | 1 | Source byte consumed on this edge |
| fifo_full | input | 1 | Peripheral buffer full flag |
| if_addr | output | ADDR_W | FIFO buffer address |
| if_cs | output | 1 | Chip select |
| if_wr | output | 1 | Write strobe |
| if_data | output | DATA_W | FIFO data bus |
| if_pkt_end | output | 1 | Packet-end commit strobe |

## Verification
Directed requests are chosen so that the final byte lands on a pending count in the middle of a packet, on zero, and on the last slot of an automatic packet. These cases separate merged, deferred and suppressed packet-end placement. One request crosses an automatic commit and ends with a single byte, which covers the deferred commit right after a full packet. Zero-length requests with and without the commit flag, plus a long burst under a dense full flag, exercise the setup-only paths and the stall-and-resume behaviour. Random requests with random lengths, flags and full-flag density, some with conflicting requests held during the busy phase, check that the address and the byte count are never disturbed.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WRITE,
        ST_PEND,
        ST_DONE
    } sfw_state_e;

endpackage

// File: rtl/sfw_byte_cnt.sv
module sfw_byte_cnt #(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero,
    output logic             is_last
);
    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (dec) begin
            rem_q <= rem_q - LEN_W'(1);
        end
    end

    assign is_zero = (rem_q == '0);
    assign is_last = (rem_q == LEN_W'(1));

    // R4: a byte is never written once the count is exhausted
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (rem_q != '0));

endmodule

// File: rtl/sfw_commit_track.sv
module sfw_commit_track #(
    parameter int AUTO_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_wr,
    input  logic pe_fire,
    output logic fill_zero,
    output logic fill_top
);
    localparam int FW = (AUTO_LEN > 2) ? $clog2(AUTO_LEN) : 1;
    localparam logic [FW-1:0] TOP = FW'(AUTO_LEN - 1);

    logic [FW-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (pe_fire) begin
            fill_q <= '0;
        end else if (byte_wr) begin
            fill_q <= (fill_q == TOP) ? '0 : fill_q + FW'(1);
        end
    end

    assign fill_zero = (fill_q == '0);
    assign fill_top  = (fill_q == TOP);

    // R7/R8/R9: packet-end never rides on a byte that opens or closes an automatic packet
    p_merge_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_fire && byte_wr) |-> (fill_q != '0 && fill_q != TOP));

    // R12: pending count stays inside one automatic packet
    p_fill_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= TOP);

endmodule

// File: rtl/sfw_ctrl.sv
module sfw_ctrl
    import sfw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_pkt_end,
    input  logic fifo_full,
    input  logic len_zero,
    input  logic len_last,
    input  logic fill_zero,
    input  logic fill_top,
    output logic req_ready,
    output logic cs_o,
    output logic wr_o,
    output logic pe_o,
    output logic done_o
);
    sfw_state_e state_q, state_d;
    logic       pe_flag_q;
    logic       write_go, last_go, merge_pe, defer_pe;

    // state register and latched commit flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pe_flag_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                pe_flag_q <= req_pkt_end;
            end
        end
    end

    // final-byte decisions shared by both combinational processes
    always_comb begin
        write_go = (state_q == ST_WRITE) && !fifo_full;
        last_go  = write_go && len_last;
        merge_pe = last_go && pe_flag_q && !fill_zero && !fill_top;
        defer_pe = last_go && pe_flag_q && fill_zero;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_SETUP;
            ST_SETUP: begin
                if (!len_zero)      state_d = ST_WRITE;
                else if (pe_flag_q) state_d = ST_PEND;
                else                state_d = ST_DONE;
            end
            ST_WRITE: begin
                if (defer_pe)     state_d = ST_PEND;
                else if (last_go) state_d = ST_DONE;
            end
            ST_PEND:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        cs_o      = 1'b0;
        wr_o      = 1'b0;
        pe_o      = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_SETUP: cs_o = 1'b1;
            ST_WRITE: begin
                cs_o = 1'b1;
                wr_o = write_go;
                pe_o = merge_pe;
            end
            ST_PEND: begin
                cs_o = 1'b1;
                pe_o = 1'b1;
            end
            ST_DONE:  done_o = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end

    // R3: no strobe without chip select
    p_cs_cover_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o || pe_o) |-> cs_o);

    // R2: the cycle in which chip select rises carries no strobe
    p_setup_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_o) |-> (!wr_o && !pe_o));

    // R11: completion pulse lasts one cycle and returns to ready
    p_done_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (req_ready && !done_o));

    // R8: a lone packet-end follows a write or the setup cycle of the same request
    p_lone_pe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_o && !wr_o) |-> $past(cs_o));

endmodule

// File: rtl/sfifo_wr_master.sv
module sfifo_wr_master #(
    parameter int ADDR_W   = 2,
    parameter int LEN_W    = 10,
    parameter int DATA_W   = 8,
    parameter int AUTO_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_pkt_end,
    output logic              req_done,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_pop,
    input  logic              fifo_full,
    output logic [ADDR_W-1:0] if_addr,
    output logic              if_cs,
    output logic              if_wr,
    output logic [DATA_W-1:0] if_data,
    output logic              if_pkt_end
);
    logic              accept;
    logic              len_zero, len_last;
    logic              fill_zero, fill_top;
    logic [ADDR_W-1:0] addr_q;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
        end
    end

    sfw_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_pkt_end (req_pkt_end),
        .fifo_full   (fifo_full),
        .len_zero    (len_zero),
        .len_last    (len_last),
        .fill_zero   (fill_zero),
        .fill_top    (fill_top),
        .req_ready   (req_ready),
        .cs_o        (if_cs),
        .wr_o        (if_wr),
        .pe_o        (if_pkt_end),
        .done_o      (req_done)
    );

    sfw_byte_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (req_len),
        .dec      (if_wr),
        .is_zero  (len_zero),
        .is_last  (len_last)
    );

    sfw_commit_track #(.AUTO_LEN(AUTO_LEN)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_wr   (if_wr),
        .pe_fire   (if_pkt_end),
        .fill_zero (fill_zero),
        .fill_top  (fill_top)
    );

    assign if_addr = addr_q;
    assign if_data = src_data;
    assign src_pop = if_wr;

    // R5: the full flag always blocks the write strobe
    p_no_wr_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !if_wr);

    // R6: address held while selected
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (if_cs && $past(if_cs)) |-> $stable(if_addr));

    // R1: a request is only taken from idle
    p_accept_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (if_cs && !req_ready));

endmodule

// File: tb/test_sfifo_wr_master.sv
module test_sfifo_wr_master;
    localparam int ADDR_W = 2;
    localparam int LEN_W  = 10;
    localparam int DATA_W = 8;
    localparam int AUTO   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_pkt_end = 1'b0;
    logic              req_done;
    logic [DATA_W-1:0] src_data = '0;
    logic              src_pop;
    logic              fifo_full = 1'b0;
    logic [ADDR_W-1:0] if_addr;
    logic              if_cs, if_wr, if_pkt_end;
    logic [DATA_W-1:0] if_data;

    int n_cmp = 0;
    int n_bad = 0;
    int fill  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sfifo_wr_master #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .AUTO_LEN(AUTO))
    i_sfifo_wr_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_pkt_end(req_pkt_end),
        .req_done(req_done), .src_data(src_data), .src_pop(src_pop),
        .fifo_full(fifo_full), .if_addr(if_addr), .if_cs(if_cs), .if_wr(if_wr),
        .if_data(if_data), .if_pkt_end(if_pkt_end)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // 0: no packet-end, 1: with final byte, 2: deferred to next cycle
    function automatic int pe_mode(input bit flag, input int fill_before);
        if (!flag)                   return 0;
        if (fill_before == AUTO - 1) return 0;
        if (fill_before == 0)        return 2;
        return 1;
    endfunction

    task automatic run_req(input int a, input int n, input bit pf, input int full_pct, input bit noise);
        int rem = n;
        int mode = (n == 0 && pf) ? 2 : 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = ADDR_W'(a); req_len = LEN_W'(n); req_pkt_end = pf;
        fifo_full = 1'b0;
        #4;
        chk(req_ready == 1'b1, "R1 ready in idle", int'(req_ready), 1);
        // setup cycle
        @(negedge clk);
        req_valid = noise; req_addr = ADDR_W'(~a); req_len = LEN_W'(n + 3); req_pkt_end = ~pf;
        fifo_full = 1'($urandom % 2);
        #4;
        chk(if_cs && !if_wr && !if_pkt_end, "R2 setup cycle", int'({if_cs, if_wr, if_pkt_end}), 4);
        chk(if_addr == ADDR_W'(a), "R2 address lead", int'(if_addr), a);
        chk(req_ready == 1'b0, "R1 busy not ready", int'(req_ready), 0);
        // burst
        while (rem > 0) begin
            bit exp_wr, exp_pe;
            @(negedge clk);
            fifo_full = (($urandom % 100) < full_pct);
            src_data  = DATA_W'($urandom);
            #4;
            exp_wr = !fifo_full;
            exp_pe = 1'b0;
            chk(if_wr == exp_wr, fifo_full ? "R5 stall on full" : "R4 burst strobe", int'(if_wr), int'(exp_wr));
            chk(if_cs == 1'b1, "R3 cs during burst", int'(if_cs), 1);
            chk(if_addr == ADDR_W'(a), "R6 address hold", int'(if_addr), a);
            if (exp_wr) begin
                chk(if_data == src_data && src_pop, "R4 data pass", int'(if_data), int'(src_data));
                if (rem == 1) begin
                    mode = pe_mode(pf, fill);
                    exp_pe = (mode == 1);
                end
                fill = (fill + 1) % AUTO;
                if (exp_pe) fill = 0;
                rem--;
            end
            chk(if_pkt_end == exp_pe, exp_pe ? "R7 merged packet-end" : "R9 no early packet-end",
                int'(if_pkt_end), int'(exp_pe));
        end
        if (mode == 2) begin
            @(negedge clk);
            fifo_full = 1'($urandom % 2);
            #4;
            chk(if_pkt_end && !if_wr && if_cs, n == 0 ? "R10 lone packet-end" : "R8 deferred packet-end",
                int'({if_cs, if_wr, if_pkt_end}), 5);
            chk(if_addr == ADDR_W'(a), "R6 address at packet-end", int'(if_addr), a);
            fill = 0;
        end
        @(negedge clk);
        req_valid = 1'b0; fifo_full = 1'b0;
        #4;
        chk(req_done && !if_cs && !if_wr && !if_pkt_end && !req_ready, n == 0 && !pf ? "R10 empty done" : "R11 done pulse",
            int'({req_done, if_cs, if_wr, if_pkt_end, req_ready}), 16);
        @(negedge clk);
        #4;
        chk(!req_done && req_ready, "R11 back to ready", int'({req_done, req_ready}), 1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        #4;
        chk(req_ready && !if_cs && !if_wr && !if_pkt_end && !req_done, "R12 reset state",
            int'({req_ready, if_cs, if_wr, if_pkt_end, req_done}), 16);
        @(negedge clk);
        rst_n = 1'b1;
        #4;
        chk(req_ready && !if_cs && !req_done, "R12 after release", int'({req_ready, if_cs, req_done}), 4);
        // directed corners
        run_req(1, 3, 1'b1, 0, 1'b0);   // R7 merged
        run_req(2, 1, 1'b1, 0, 1'b0);   // R8 deferred
        run_req(3, 8, 1'b1, 0, 1'b1);   // R9 completes automatic packet
        run_req(0, 0, 1'b1, 0, 1'b0);   // R10 lone commit
        run_req(1, 0, 1'b0, 0, 1'b1);   // R10 empty
        run_req(2, 5, 1'b0, 0, 1'b0);
        run_req(3, 4, 1'b1, 0, 1'b0);   // R8 one byte after automatic commit
        run_req(0, 20, 1'b1, 60, 1'b1); // R5 dense stalls
        // random
        for (int k = 0; k < 40; k++) begin
            run_req(int'($urandom % 4), int'($urandom % 21), 1'($urandom % 2),
                    int'($urandom % 50), 1'($urandom % 2));
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule